// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller with Fast-Path Mirrors

This block collects level-sensitive interrupt requests from three banks and drives a single interrupt line to the processor. The primary bank holds 8 direct sources. Two secondary banks hold 32 sources each. Every bank has a status register that shows its enabled, asserted sources. Every bank also has a set-one-to-enable register and a set-one-to-disable register, reached through a simple register port.

The primary status word carries more than the primary bank's own sources. One bit flags pending activity in each secondary bank. A further group of bits mirrors a fixed selection of frequently used secondary sources. Software can therefore often find the source from a single read.

A mirrored source never raises its bank's summary flag. It still sets its own bit in its bank's status register. Neither the summary flags nor the mirror bits can be masked from the primary bank. A mirror is masked only through the enable state of the bank the source belongs to.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, all enable state is 0, `irq` is 0, and every status register reads 0 even while all sources are high.
- R2: A write to an enable register sets the enable bits where `wdata` has a 1. A write to a disable register clears them. A 0 in `wdata` leaves the bit unchanged. Enable registers read back the current enable state, and disable registers read 0. The enable offsets are 0x18, 0x10 and 0x14, and the disable offsets are 0x24, 0x1C and 0x20, for banks 0, 1 and 2 in that order.
- R3: Status bit n of a bank is source n's level ANDed with its enable bit. It follows the level, so it clears when the source drops. The status offsets are 0x00, 0x04 and 0x08 for banks 0, 1 and 2.
- R4: Bit 8 of the bank 0 status is set when any non-mirrored bank 1 source is pending. Bit 9 does the same for bank 2.
- R5: Bank 0 status bits 10 to 14 mirror bank 1 sources 7, 9, 10, 18 and 19, in that order. Bits 15 to 20 mirror bank 2 sources 21, 22, 23, 24, 25 and 30, in that order.
- R6: A pending mirrored source sets its mirror bit and its own bank status bit, but not its bank's summary bit.
- R7: Writes to the bank 0 enable or disable registers at bits 8 and above have no effect, and those bits read back as 0. The summary and mirror bits therefore stay visible when all bank 0 enables are off.
- R8: `irq` is the OR of bank 0 status bits 0 to 20, registered, so it changes one clock after its cause.
- R9: `rdata` is registered and shows, one clock after `addr` is presented, the register at that offset. Unmapped offsets and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| src0 | input | 8 | Bank 0 source levels |
| src1 | input | 32 | Bank 1 source levels |
| src2 | input | 32 | Bank 2 source levels |
| irq | output | 1 | Registered interrupt request to the processor |

## Verification
The status logic is driven with each source pattern that a wrong mapping would confuse. The patterns are a lone direct source, a lone non-mirrored secondary source (summary only), a lone mirrored source (mirror bit but no summary), and mixes of the two in one bank. The mixes show that the summary and mirror bits are formed independently. Directed cases then show three things: disabling a mirrored source at its home bank removes its mirror bit, bank 0 writes cannot reach bits 8 and above, and the summary and mirror bits still raise `irq` when every bank 0 enable is off. Dropping a source confirms level behaviour. Reads of unmapped offsets confirm the zero default.

// File: rtl/bic_pkg.sv
package bic_pkg;
  localparam int DATA_W  = 32;
  localparam int B0_SRCS = 8;
  localparam int ADDR_W  = 6;

  // register offsets (software-visible, fixed)
  localparam int OFF_PEND0 = 'h00;
  localparam int OFF_PEND1 = 'h04;
  localparam int OFF_PEND2 = 'h08;
  localparam int OFF_EN1   = 'h10;
  localparam int OFF_EN2   = 'h14;
  localparam int OFF_EN0   = 'h18;
  localparam int OFF_DIS1  = 'h1C;
  localparam int OFF_DIS2  = 'h20;
  localparam int OFF_DIS0  = 'h24;

  // bank 0 status layout
  localparam int SUM1_BIT = 8;
  localparam int SUM2_BIT = 9;
  localparam int MIR1_N   = 5;
  localparam int MIR2_N   = 6;
  localparam int MIR1_BASE = 10;
  localparam int MIR2_BASE = MIR1_BASE + MIR1_N;
  localparam int P0_USED  = MIR2_BASE + MIR2_N;

  localparam int MIR1_IDX [MIR1_N] = '{7, 9, 10, 18, 19};
  localparam int MIR2_IDX [MIR2_N] = '{21, 22, 23, 24, 25, 30};

  function automatic logic [DATA_W-1:0] mir1_mask();
    logic [DATA_W-1:0] m = '0;
    for (int k = 0; k < MIR1_N; k++) m[MIR1_IDX[k]] = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] mir2_mask();
    logic [DATA_W-1:0] m = '0;
    for (int k = 0; k < MIR2_N; k++) m[MIR2_IDX[k]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/bic_enable_bank.sv
module bic_enable_bank
  import bic_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter logic [DATA_W-1:0] WMASK = '1,
  parameter int EN_OFF = 0,
  parameter int DIS_OFF = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] en_o
);
  localparam logic [AW-1:0] EN_A  = AW'(EN_OFF);
  localparam logic [AW-1:0] DIS_A = AW'(DIS_OFF);

  logic set_hit, clr_hit;
  logic [DATA_W-1:0] wsel;

  assign set_hit = wr_en && (addr == EN_A);
  assign clr_hit = wr_en && (addr == DIS_A);
  assign wsel    = wdata & WMASK;

  always_ff @(posedge clk) begin
    if (rst) en_o <= '0;
    else if (set_hit) en_o <= en_o | wsel;
    else if (clr_hit) en_o <= en_o & ~wsel;
  end

  // R2: write-one-to-enable sets the selected bits
  p_enable_sets_r2: assert property (@(posedge clk) disable iff (rst)
    set_hit |=> ((en_o & $past(wsel)) == $past(wsel)));
  // R2: write-one-to-disable clears the selected bits
  p_disable_clears_r2: assert property (@(posedge clk) disable iff (rst)
    clr_hit |=> ((en_o & $past(wsel)) == '0));
  // R7: bits outside the writable set never change
  p_locked_bits_r7: assert property (@(posedge clk) disable iff (rst)
    (set_hit || clr_hit) |=> ((en_o & ~WMASK) == ($past(en_o) & ~WMASK)));
endmodule

// File: rtl/bic_status.sv
module bic_status
  import bic_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [B0_SRCS-1:0] src0,
  input  logic [DATA_W-1:0] src1,
  input  logic [DATA_W-1:0] src2,
  input  logic [DATA_W-1:0] en0,
  input  logic [DATA_W-1:0] en1,
  input  logic [DATA_W-1:0] en2,
  output logic [DATA_W-1:0] p0,
  output logic [DATA_W-1:0] p1,
  output logic [DATA_W-1:0] p2
);
  localparam logic [DATA_W-1:0] M1 = mir1_mask();
  localparam logic [DATA_W-1:0] M2 = mir2_mask();

  assign p1 = src1 & en1;
  assign p2 = src2 & en2;

  assign p0[B0_SRCS-1:0] = src0 & en0[B0_SRCS-1:0];
  assign p0[SUM1_BIT]    = |(p1 & ~M1);
  assign p0[SUM2_BIT]    = |(p2 & ~M2);

  for (genvar k = 0; k < MIR1_N; k++) begin : g_mir1
    assign p0[MIR1_BASE + k] = p1[MIR1_IDX[k]];
  end
  for (genvar k = 0; k < MIR2_N; k++) begin : g_mir2
    assign p0[MIR2_BASE + k] = p2[MIR2_IDX[k]];
  end

  assign p0[DATA_W-1:P0_USED] = '0;

  // R6: only mirrored bank 1 activity -> no bank 1 summary
  p_mirror_no_sum1_r6: assert property (@(posedge clk) disable iff (rst)
    ((p1 & ~M1) == '0) |-> !p0[SUM1_BIT]);
  // R6: only mirrored bank 2 activity -> no bank 2 summary
  p_mirror_no_sum2_r6: assert property (@(posedge clk) disable iff (rst)
    ((p2 & ~M2) == '0) |-> !p0[SUM2_BIT]);
  // R5: first bank 1 mirror tracks source 7 status
  p_mirror_first_r5: assert property (@(posedge clk) disable iff (rst)
    p0[MIR1_BASE] == p1[MIR1_IDX[0]]);
  // R3: a disabled source never shows in its bank
  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    ((p1 & ~en1) == '0) && ((p2 & ~en2) == '0));
endmodule

// File: rtl/bic_readback.sv
module bic_readback
  import bic_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] p0,
  input  logic [DATA_W-1:0] p1,
  input  logic [DATA_W-1:0] p2,
  input  logic [DATA_W-1:0] en0,
  input  logic [DATA_W-1:0] en1,
  input  logic [DATA_W-1:0] en2,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    case (addr)
      AW'(OFF_PEND0): sel = p0;
      AW'(OFF_PEND1): sel = p1;
      AW'(OFF_PEND2): sel = p2;
      AW'(OFF_EN0):   sel = en0;
      AW'(OFF_EN1):   sel = en1;
      AW'(OFF_EN2):   sel = en2;
      default:        sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import bic_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [B0_SRCS-1:0] src0,
  input  logic [DATA_W-1:0]  src1,
  input  logic [DATA_W-1:0]  src2,
  output logic               irq
);
  localparam logic [DATA_W-1:0] B0_WMASK = DATA_W'((64'd1 << B0_SRCS) - 1);

  logic [DATA_W-1:0] en0, en1, en2, p0, p1, p2;
  logic any_pend;

  bic_enable_bank #(.AW(ADDR_W), .WMASK(B0_WMASK), .EN_OFF(OFF_EN0), .DIS_OFF(OFF_DIS0))
    u_en0 (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .en_o(en0));
  bic_enable_bank #(.AW(ADDR_W), .WMASK('1), .EN_OFF(OFF_EN1), .DIS_OFF(OFF_DIS1))
    u_en1 (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .en_o(en1));
  bic_enable_bank #(.AW(ADDR_W), .WMASK('1), .EN_OFF(OFF_EN2), .DIS_OFF(OFF_DIS2))
    u_en2 (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .en_o(en2));

  bic_status u_status (
    .clk(clk), .rst(rst), .src0(src0), .src1(src1), .src2(src2),
    .en0(en0), .en1(en1), .en2(en2), .p0(p0), .p1(p1), .p2(p2)
  );

  bic_readback #(.AW(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .addr(addr), .p0(p0), .p1(p1), .p2(p2),
    .en0(en0), .en1(en1), .en2(en2), .rdata(rdata)
  );

  assign any_pend = |p0[P0_USED-1:0];

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= any_pend;
  end

  // R8: irq follows the bank 0 status OR one cycle later
  p_irq_follows_r8: assert property (@(posedge clk) disable iff (rst)
    ##1 (irq == $past(any_pend)));
  // R1: nothing pending while no enables exist at all
  p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (rst)
    ((en0 | en1 | en2) == '0) |-> (p0 == '0));
endmodule

// File: tb/banked_irq_ctrl_tb.sv
module banked_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;

  localparam logic [7:0]  VB0 [NV] = '{8'h00, 8'h81, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
  localparam logic [31:0] VB1 [NV] = '{32'h0, 32'h0, 32'h80, 32'h1, 32'h80008, 32'h0, 32'h0, 32'h0, 32'h40600};
  localparam logic [31:0] VB2 [NV] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h40000000, 32'h200001, 32'h03C00000, 32'h0};
  localparam logic [31:0] EP0 [NV] = '{32'h0, 32'h81, 32'h400, 32'h100, 32'h4100, 32'h100000, 32'h8200, 32'hF0000, 32'h3800};
  localparam logic [31:0] EP1 [NV] = '{32'h0, 32'h0, 32'h80, 32'h1, 32'h80008, 32'h0, 32'h0, 32'h0, 32'h40600};
  localparam logic [31:0] EP2 [NV] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h40000000, 32'h200001, 32'h03C00000, 32'h0};
  localparam logic        EIRQ [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0] src0 = '0;
  logic [31:0] src1 = '0, src2 = '0;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .src0(src0), .src1(src1), .src2(src2), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // present addr at a falling edge; value is registered at the next rising edge
  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic set_src(input logic [7:0] a, input logic [31:0] b, input logic [31:0] c);
    @(negedge clk);
    src0 = a; src1 = b; src2 = c;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state with every source high
    set_src(8'hFF, '1, '1);
    rd(6'h00, v); check("R1 pend0 after reset", v, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd(6'h04, v); check("R1 pend1 after reset", v, 32'h0);
    rd(6'h08, v); check("R1 pend2 after reset", v, 32'h0);
    rd(6'h10, v); check("R1 en1 after reset", v, 32'h0);

    // R7: bank 0 enables only reach bits 0..7
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, v); check("R7 en0 upper bits locked", v, 32'h0000_00FF);
    wr(6'h24, 32'hFFFF_FF00);
    rd(6'h18, v); check("R7 dis0 upper bits no effect", v, 32'h0000_00FF);

    // R2: enable banks 1 and 2
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h14, 32'hFFFF_FFFF);
    rd(6'h10, v); check("R2 en1 readback", v, 32'hFFFF_FFFF);
    rd(6'h1C, v); check("R2 disable register reads 0", v, 32'h0);

    // R3 R4 R5 R6 R8: vector table
    for (int i = 0; i < NV; i++) begin
      set_src(VB0[i], VB1[i], VB2[i]);
      rd(6'h00, v); check($sformatf("R4/R5/R6 pend0 vec %0d", i), v, EP0[i]);
      check($sformatf("R8 irq vec %0d", i), {31'b0, irq}, {31'b0, EIRQ[i]});
      rd(6'h04, v); check($sformatf("R3 pend1 vec %0d", i), v, EP1[i]);
      rd(6'h08, v); check($sformatf("R3 pend2 vec %0d", i), v, EP2[i]);
    end

    // R2 R5: disabling mirrored source at home bank removes the mirror bit
    wr(6'h1C, 32'h0000_0080);
    set_src(8'h00, 32'h80, 32'h0);
    rd(6'h00, v); check("R5 mirror masked via bank 1", v, 32'h0);
    check("R8 irq low when mirror masked", {31'b0, irq}, 32'h0);
    rd(6'h10, v); check("R2 en1 after disable bit 7", v, 32'hFFFF_FF7F);

    // R7: summary and mirror stay visible with all bank 0 enables off
    wr(6'h24, 32'h0000_00FF);
    set_src(8'hFF, 32'h1, 32'h4000_0000);
    rd(6'h00, v); check("R7 summary/mirror unmaskable in bank 0", v, 32'h0010_0100);
    check("R7 irq from summary", {31'b0, irq}, 32'h1);

    // R3: level behaviour, status clears as sources drop
    set_src(8'h00, 32'h0, 32'h0);
    rd(6'h00, v); check("R3 level clear pend0", v, 32'h0);
    check("R8 irq clears", {31'b0, irq}, 32'h0);

    // R9: unmapped offsets read 0
    rd(6'h0C, v); check("R9 unmapped 0x0C", v, 32'h0);
    rd(6'h3C, v); check("R9 unmapped 0x3C", v, 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule